// File: doc/BRIEF.md
# Four-Port Sticky Interrupt Combiner

This block collects event interrupts from a group of PHY ports and drives one shared active-low interrupt line. Every port has its own latch register, where incoming event pulses set sticky bits, and its own per-bit enable register that chooses which latched bits may drive the shared line. A management slave reaches all of these registers through a simple single-cycle register access port. It picks a port and a register address, then either writes a data word or asks for a read.

A read of a port's latch register returns the pending sources and clears them in the same access. This releases that port's share of the interrupt line. Each port also has a configuration register that holds one flag. The flag asks the management slave to signal interrupts embedded in the serial management data line as well as on the dedicated pin. This block only presents that flag. The signalling itself, and the detection of the events, are handled elsewhere.

Top module: `intr_aggregator`

## Requirements
- R1: After reset every latch and enable bit is 0, every embedded-signalling flag is 0, `irq_n_o` is 1 and `acc_rdata_o` is 0.
- R2: A 1 on bit b of a port's event input sets bit b of that port's latch register (address 5'h1E) at the next clock. The bit stays set until that register is read.
- R3: `irq_n_o` is 0 exactly when some port has a latch bit set whose enable bit is also 1. It follows the registered state with no extra cycle of delay.
- R4: A read access (`acc_en_i`=1, `acc_we_i`=0) to address 5'h1E returns the port's latch contents on `acc_rdata_o` after the next clock edge and clears them at that edge. `acc_rdata_o` holds its value until the next read access.
- R5: An event that arrives in the same cycle as a clearing read of its port stays set after that read. It is not included in that read's data.
- R6: A latch bit is recorded even while its enable bit is 0. Setting the enable bit later drives `irq_n_o` low in the cycle after the write.
- R7: Address 5'h1D is the per-port enable register. It is fully readable and writable, and 1 means the source may drive the line.
- R8: Writing address 5'h17 copies data bit 11 into that port's `embed_en_o` bit. A read of 5'h17 returns the flag in bit 11 and 0 in all other bits.
- R9: Writes to the latch register have no effect. Reads of any other address return 0, and writes to any other address change nothing.
- R10: A clearing read affects only the addressed port. Other ports keep their latched bits and their share of the interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | NPORT*16 | Event pulses, 16 per port, port 0 in the low bits |
| acc_en_i | input | 1 | Register access strobe, one cycle per access |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_port_i | input | PW | Port selected by the access |
| acc_addr_i | input | 5 | Register address |
| acc_wdata_i | input | 16 | Write data |
| acc_rdata_o | output | 16 | Registered read data of the last read access |
| irq_n_o | output | 1 | Combined interrupt, active low |
| embed_en_o | output | NPORT | Per-port request to also signal interrupts on the management data line |

## Verification
The hardest case to reach from the ports is an event on a port arriving on the same clock edge that its latch register is being read and cleared. The read data and the surviving bit must then split cleanly between two reads. The bench has a task that raises an event pulse and a clearing read on the same edge, with different bits on the same port. After that it runs a long stretch where random event pulses and random accesses overlap freely. A behavioural model, kept as plain integer arrays, is compared with every output on every cycle.

// File: rtl/intr_pkg.sv
package intr_pkg;
    localparam int REG_W     = 16;
    localparam int ADDR_W    = 5;
    localparam logic [ADDR_W-1:0] ADDR_CFG  = 5'h17;
    localparam logic [ADDR_W-1:0] ADDR_MASK = 5'h1D;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 5'h1E;
    localparam int EMBED_BIT = 11;

    typedef struct packed {
        logic [REG_W-1:0] status;
        logic [REG_W-1:0] mask;
        logic             embed;
    } port_state_t;
endpackage

// File: rtl/intr_port_regs.sv
module intr_port_regs
    import intr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [REG_W-1:0]  evt_i,
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  status_o,
    output logic [REG_W-1:0]  mask_o,
    output logic              embed_o,
    output logic              pend_o
);
    port_state_t st_d, st_q;
    logic        rd_clr;

    always_comb begin
        st_d   = st_q;
        rd_clr = sel_i && !we_i && (addr_i == ADDR_STAT);
        if (sel_i && we_i && addr_i == ADDR_MASK) st_d.mask  = wdata_i;
        if (sel_i && we_i && addr_i == ADDR_CFG)  st_d.embed = wdata_i[EMBED_BIT];
        st_d.status = (st_q.status & ~{REG_W{rd_clr}}) | evt_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
    assign embed_o  = st_q.embed;
    assign pend_o   = |(st_q.status & st_q.mask);

    // R2: latched bits never drop without a clearing read
    assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_clr |=> ((status_o & $past(status_o)) == $past(status_o)));
    // R4: a clearing read with no new event leaves the register empty
    assert_clear_on_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_clr && evt_i == '0) |=> (status_o == '0));
    // R5: an incoming event is never lost, even during a clearing read
    assert_event_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((status_o & $past(evt_i)) == $past(evt_i)));
    // R8: the flag follows bit 11 of a config write
    assert_embed_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && we_i && addr_i == ADDR_CFG) |=> (embed_o == $past(wdata_i[EMBED_BIT])));
endmodule

// File: rtl/intr_rd_mux.sv
module intr_rd_mux
    import intr_pkg::*;
#(
    parameter int NPORT = 4,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic [NPORT-1:0][REG_W-1:0] status_i,
    input  logic [NPORT-1:0][REG_W-1:0] mask_i,
    input  logic [NPORT-1:0]            embed_i,
    input  logic [PW-1:0]               port_i,
    input  logic [ADDR_W-1:0]           addr_i,
    output logic [REG_W-1:0]            data_o
);
    always_comb begin
        data_o = '0;
        if (int'(port_i) < NPORT) begin
            unique case (addr_i)
                ADDR_STAT: data_o = status_i[port_i];
                ADDR_MASK: data_o = mask_i[port_i];
                ADDR_CFG:  data_o[EMBED_BIT] = embed_i[port_i];
                default:   data_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/intr_aggregator.sv
module intr_aggregator
    import intr_pkg::*;
#(
    parameter int NPORT = 4,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NPORT*REG_W-1:0] evt_i,
    input  logic                   acc_en_i,
    input  logic                   acc_we_i,
    input  logic [PW-1:0]          acc_port_i,
    input  logic [ADDR_W-1:0]      acc_addr_i,
    input  logic [REG_W-1:0]       acc_wdata_i,
    output logic [REG_W-1:0]       acc_rdata_o,
    output logic                   irq_n_o,
    output logic [NPORT-1:0]       embed_en_o
);
    typedef struct packed {
        logic [REG_W-1:0] rdata;
    } top_state_t;

    logic [NPORT-1:0][REG_W-1:0] status_all, mask_all;
    logic [NPORT-1:0]            pend_all;
    logic [REG_W-1:0]            mux_data;
    top_state_t                  top_d, top_q;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        intr_port_regs u_regs (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .evt_i    (evt_i[g*REG_W +: REG_W]),
            .sel_i    (acc_en_i && (acc_port_i == PW'(g))),
            .we_i     (acc_we_i),
            .addr_i   (acc_addr_i),
            .wdata_i  (acc_wdata_i),
            .status_o (status_all[g]),
            .mask_o   (mask_all[g]),
            .embed_o  (embed_en_o[g]),
            .pend_o   (pend_all[g])
        );
    end

    intr_rd_mux #(.NPORT(NPORT)) u_mux (
        .status_i (status_all),
        .mask_i   (mask_all),
        .embed_i  (embed_en_o),
        .port_i   (acc_port_i),
        .addr_i   (acc_addr_i),
        .data_o   (mux_data)
    );

    always_comb begin
        top_d = top_q;
        if (acc_en_i && !acc_we_i) top_d.rdata = mux_data;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) top_q <= '0;
        else         top_q <= top_d;
    end

    assign acc_rdata_o = top_q.rdata;
    assign irq_n_o     = ~|pend_all;

    // R3: the line is low only while some port holds an enabled, latched bit
    assert_irq_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_n_o |-> (|(status_all & mask_all)));
    // R4: read data only changes on a read access
    assert_rdata_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(acc_en_i && !acc_we_i) |=> $stable(acc_rdata_o));
endmodule

// File: tb/sim_intr_aggregator.sv
module sim_intr_aggregator;
    localparam int NP = 4;
    localparam int W  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP*W-1:0] evt = '0;
    logic          en = 1'b0, we = 1'b0;
    logic [1:0]    port = '0;
    logic [4:0]    addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic          irq_n;
    logic [NP-1:0] embed;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    int unsigned m_st[NP], m_mk[NP], m_cf[NP];
    int unsigned m_rd;

    intr_aggregator #(.NPORT(NP)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .acc_en_i(en), .acc_we_i(we),
        .acc_port_i(port), .acc_addr_i(addr), .acc_wdata_i(wdata),
        .acc_rdata_o(rdata), .irq_n_o(irq_n), .embed_en_o(embed));

    always #5 clk = ~clk;

    task automatic check(string tag, int unsigned act, int unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural model, updated on each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin m_st[i] = 0; m_mk[i] = 0; m_cf[i] = 0; end
            m_rd = 0;
        end else begin
            int p;
            p = int'(port);
            if (en && !we) begin
                case (addr)
                    5'h1E: m_rd = m_st[p];
                    5'h1D: m_rd = m_mk[p];
                    5'h17: m_rd = m_cf[p] << 11;
                    default: m_rd = 0;
                endcase
                if (addr == 5'h1E) m_st[p] = 0;
            end
            if (en && we) begin
                if (addr == 5'h1D) m_mk[p] = 32'(wdata);
                if (addr == 5'h17) m_cf[p] = 32'(wdata[11]);
            end
            for (int i = 0; i < NP; i++) m_st[i] = m_st[i] | 32'(evt[i*W +: W]);
        end
    end

    // every-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit any;
            int unsigned emb;
            any = 0; emb = 0;
            for (int i = 0; i < NP; i++) begin
                if ((m_st[i] & m_mk[i]) != 0) any = 1;
                emb = emb | (m_cf[i] << i);
            end
            check("R3 irq_n", 32'(irq_n), any ? 0 : 1);
            check("R4 rdata", 32'(rdata), m_rd);
            check("R8 embed", 32'(embed), emb);
        end
    end

    task automatic idle();
        @(posedge clk); #1;
        en = 0; we = 0; evt = '0;
    endtask

    task automatic wr(int p, logic [4:0] a, logic [15:0] d);
        @(posedge clk); #1;
        en = 1; we = 1; port = 2'(p); addr = a; wdata = d; evt = '0;
        idle();
    endtask

    task automatic pulse(int p, logic [15:0] bits);
        @(posedge clk); #1;
        en = 0; we = 0; evt = '0; evt[p*W +: W] = bits;
        idle();
    endtask

    // read, optionally with an event on the same edge; returns data after the edge
    task automatic rd_ev(int p, logic [4:0] a, logic [15:0] bits, output logic [15:0] d);
        @(posedge clk); #1;
        en = 1; we = 0; port = 2'(p); addr = a; evt = '0; evt[p*W +: W] = bits;
        idle();
        @(negedge clk);
        d = rdata;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq_n", 32'(irq_n), 1);
        check("R1 rdata", 32'(rdata), 0);
        check("R1 embed", 32'(embed), 0);
        rd_ev(2, 5'h1D, 0, d); check("R1 mask", 32'(d), 0);

        // R6 masked bit latched, unmask asserts
        pulse(1, 16'h0008);
        @(negedge clk); check("R6 masked irq_n", 32'(irq_n), 1);
        wr(1, 5'h1D, 16'h0008);
        @(negedge clk); check("R6 unmask irq_n", 32'(irq_n), 0);
        rd_ev(1, 5'h1D, 0, d); check("R7 mask readback", 32'(d), 16'h0008);
        rd_ev(1, 5'h1E, 0, d); check("R2 status", 32'(d), 16'h0008);
        check("R4 released irq_n", 32'(irq_n), 1);
        rd_ev(1, 5'h1E, 0, d); check("R4 cleared", 32'(d), 0);

        // R5 event on the clearing edge survives
        wr(2, 5'h1D, 16'hFFFF);
        pulse(2, 16'h0001);
        rd_ev(2, 5'h1E, 16'h0020, d); check("R5 read data", 32'(d), 16'h0001);
        check("R5 irq_n", 32'(irq_n), 0);
        rd_ev(2, 5'h1E, 0, d); check("R5 kept", 32'(d), 16'h0020);

        // R9 status write ignored, unmapped reads zero
        pulse(0, 16'h0004);
        wr(0, 5'h1E, 16'hFFFF);
        wr(0, 5'h05, 16'hFFFF);
        rd_ev(0, 5'h1E, 0, d); check("R9 status write", 32'(d), 16'h0004);
        rd_ev(0, 5'h05, 0, d); check("R9 unmapped read", 32'(d), 0);
        rd_ev(0, 5'h1D, 0, d); check("R9 unmapped write", 32'(d), 0);

        // R10 clear only the addressed port
        wr(3, 5'h1D, 16'h8000);
        pulse(0, 16'h0002);
        pulse(3, 16'h8000);
        rd_ev(0, 5'h1E, 0, d); check("R10 port0", 32'(d), 16'h0002);
        check("R10 irq_n", 32'(irq_n), 0);
        rd_ev(3, 5'h1E, 0, d); check("R10 port3", 32'(d), 16'h8000);

        // R8 flag
        wr(3, 5'h17, 16'hFFFF);
        @(negedge clk); check("R8 embed", 32'(embed), 4'b1000);
        rd_ev(3, 5'h17, 0, d); check("R8 readback", 32'(d), 16'h0800);
        wr(3, 5'h17, 16'hF7FF);
        @(negedge clk); check("R8 embed off", 32'(embed), 0);

        // random overlap of events and accesses
        for (int k = 0; k < 3000; k++) begin
            @(posedge clk); #1;
            evt = '0;
            if ($urandom_range(0, 3) == 0)
                evt[$urandom_range(0, NP-1)*W + $urandom_range(0, W-1)] = 1'b1;
            en = ($urandom_range(0, 1) == 1);
            we = ($urandom_range(0, 2) == 0);
            port = 2'($urandom_range(0, NP-1));
            case ($urandom_range(0, 3))
                0: addr = 5'h1E;
                1: addr = 5'h1D;
                2: addr = 5'h17;
                default: addr = 5'($urandom_range(0, 31));
            endcase
            wdata = 16'($urandom);
        end
        idle();
        repeat (2) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule